// File: doc/BRIEF.md
# Multi-mode DAC serial host controller

This block drives a multi-channel DAC over a three-wire serial link: a frame strobe (`sync_n`, active low), a serial clock (`sclk`) and a data line (`din`). It also reads back the device's return line (`dout`). One command on the command port produces one of three frame shapes. A direct-hold write sends 10 bits. A DAC-mode write sends 24 bits. A readback request runs a 10-bit setup write, a mandatory idle gap, then a 14-bit read frame whose returned bits are assembled and presented with a one-cycle strobe.

The serial clock is derived from the system clock. Each half period lasts a fixed number of system cycles, with a shorter value for direct-hold frames and a longer value for all other frames. After every frame the strobe is held high for at least a parameterised number of cycles, so the device always sees its required settling time before the next frame. Data is shifted MSB first and changes only on rising serial-clock edges; the device samples on falling edges, and the controller samples `dout` on those same falling edges. An elaboration-time check refuses divider and gap settings that would violate the minimum pulse widths, maximum clock rates or 400 ns gap at the given system-clock period.

Top module: `dac_serial_host`

## Requirements
- R1: After reset `sync_n` is 1 and `sclk`, `din`, `busy`, `done` and `rd_valid` are 0.
- R2: A command with `cmd_kind` 0 (direct hold) produces one frame of exactly 10 falling `sclk` edges, carrying `cmd_word[9:0]` MSB first on `din`, sampled at the falling edges.
- R3: A command with `cmd_kind` 1 (DAC mode) produces one frame of exactly 24 falling edges carrying `cmd_word[23:0]` MSB first.
- R4: A command with `cmd_kind` 2 (readback) produces a 10-bit setup frame carrying `cmd_word[9:0]` MSB first, followed by a 14-edge read frame during which `din` stays 0.
- R5: In a read frame `dout` is captured at each falling `sclk` edge, MSB first; `rd_valid` is high for exactly one cycle, in the cycle following the system-clock edge that makes the 14th falling edge, with `rd_data` holding the 14 captured bits.
- R6: While `sync_n` is low, every run of constant `sclk` lasts HALF_FAST system cycles in a direct-hold frame and HALF_SLOW cycles in every other frame, including the low lead-in after `sync_n` falls and the low tail before it rises; `sclk` is 0 whenever `sync_n` is 1, so `sync_n` always falls with `sclk` low.
- R7: `sync_n` stays high for at least GAP_CYC cycles after every frame before falling again, and for exactly GAP_CYC cycles between the setup frame and the read frame of a readback.
- R8: `sync_n` falls and `busy` rises in the cycle after a command is accepted; `busy` stays high through the whole sequence; `cmd_valid` while busy, and any command with `cmd_kind` 3, start no frame.
- R9: `done` is a one-cycle pulse in the first cycle in which `busy` is low again, and a command presented in that cycle is accepted.
- R10: Within a frame, `din` changes only in cycles in which `sclk` rises, apart from the cycle in which `sync_n` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_kind | input | 2 | 0 direct hold, 1 DAC mode, 2 readback, 3 ignored |
| cmd_word | input | 24 | Payload; low 10 bits for kinds 0 and 2 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| sclk | output | 1 | Serial clock to the device |
| sync_n | output | 1 | Active-low frame strobe |
| din | output | 1 | Serial data to the device |
| dout | input | 1 | Serial data returned by the device |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | 14 | Assembled readback word |

## Verification
The end of one sequence and the acceptance of the next command fall in the same cycle: `done` pulses and `busy` drops together, and a command waiting at the port is taken at once. The bench provokes this by queueing commands back to back, so each driver call presents its command in the first idle cycle. It then judges that `done` was high in that cycle, that `sync_n` falls one cycle later, and that the gap counted on the pins still meets the minimum. Commands injected while busy, including one placed inside the gap of a readback, are judged by the absence of any unexpected frame on the pins.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
  localparam int WORD_W    = 24;
  localparam int LEN_W     = 5;
  localparam int LEN_SHORT = 10;
  localparam int LEN_LONG  = 24;
  localparam int LEN_READ  = 14;

  typedef enum logic [1:0] {
    K_HOLD = 2'd0,
    K_DAC  = 2'd1,
    K_RDBK = 2'd2,
    K_NONE = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_HIGH,
    S_LOW,
    S_GAP
  } st_e;

  // Number of serial bits in the first frame of a command.
  function automatic logic [LEN_W-1:0] frame_len(kind_e k);
    case (k)
      K_DAC:   return LEN_W'(LEN_LONG);
      default: return LEN_W'(LEN_SHORT);
    endcase
  endfunction

  // Places the len-bit payload so that its MSB sits at the top of the word.
  function automatic logic [WORD_W-1:0] align_msb(logic [WORD_W-1:0] w,
                                                  logic [LEN_W-1:0] len);
    return w << (WORD_W - int'(len));
  endfunction

  // True when a half period of `half` cycles meets a pulse minimum and
  // a full period minimum, all in picoseconds.
  function automatic bit half_ok(int half, int clk_ps, int min_pulse_ps,
                                 int min_period_ps);
    return (half >= 1) && (half * clk_ps >= min_pulse_ps) &&
           (2 * half * clk_ps >= min_period_ps);
  endfunction
endpackage

// File: rtl/dsh_timer.sv
module dsh_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/dsh_shift.sv
module dsh_shift #(
  parameter int W  = 24,
  parameter int RW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_word,
  input  logic          shift,
  input  logic          rx_clr,
  input  logic          capture,
  input  logic          dout,
  output logic          tx_msb,
  output logic [RW-1:0] rx_word
);
  logic [W-1:0]  tx;
  logic [RW-1:0] rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx <= '0;
    end else if (load) begin
      tx <= load_word;
    end else if (shift) begin
      tx <= {tx[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx <= '0;
    end else if (rx_clr) begin
      rx <= '0;
    end else if (capture) begin
      rx <= {rx[RW-2:0], dout};
    end
  end

  assign tx_msb  = tx[W-1];
  assign rx_word = rx;
endmodule

// File: rtl/dsh_seq.sv
module dsh_seq
  import dsh_pkg::*;
#(
  parameter int TW        = 8,
  parameter int HALF_FAST = 5,
  parameter int HALF_SLOW = 8,
  parameter int GAP_CYC   = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic             tmr_expire,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic             sh_load,
  output logic             sh_take_cmd,
  output logic [LEN_W-1:0] sh_len,
  output logic             sh_shift,
  output logic             sh_capture,
  output logic             sh_rx_clr,
  output logic             sclk,
  output logic             sync_n,
  output logic             busy,
  output logic             done,
  output logic             rd_valid,
  output logic             in_read,
  output logic             ev_fall,
  output logic             ev_accept
);
  localparam logic [TW-1:0] HF = TW'(HALF_FAST);
  localparam logic [TW-1:0] HS = TW'(HALF_SLOW);
  localparam logic [TW-1:0] GP = TW'(GAP_CYC);

  st_e             st;
  kind_e           kind;
  logic [TW-1:0]   half_r;
  logic [LEN_W-1:0] bits_left;
  logic            read_pend;

  assign kind      = kind_e'(cmd_kind);
  assign busy      = (st != S_IDLE);
  assign ev_accept = (st == S_IDLE) && cmd_valid && (kind != K_NONE);
  assign ev_fall   = (st == S_HIGH) && tmr_expire;

  always_comb begin
    tmr_load    = 1'b0;
    tmr_val     = half_r;
    sh_load     = 1'b0;
    sh_take_cmd = 1'b0;
    sh_len      = frame_len(kind);
    sh_shift    = 1'b0;
    sh_capture  = 1'b0;
    sh_rx_clr   = 1'b0;
    case (st)
      S_IDLE: begin
        if (ev_accept) begin
          tmr_load    = 1'b1;
          tmr_val     = (kind == K_HOLD) ? HF : HS;
          sh_load     = 1'b1;
          sh_take_cmd = 1'b1;
        end
      end
      S_LEAD: begin
        tmr_load = tmr_expire;
      end
      S_HIGH: begin
        tmr_load   = tmr_expire;
        sh_capture = tmr_expire && in_read;
      end
      S_LOW: begin
        if (tmr_expire) begin
          tmr_load = 1'b1;
          if (bits_left == '0) begin
            tmr_val = GP;
            sh_load = 1'b1;
          end else begin
            sh_shift = 1'b1;
          end
        end
      end
      S_GAP: begin
        if (tmr_expire && read_pend) begin
          tmr_load  = 1'b1;
          tmr_val   = HS;
          sh_load   = 1'b1;
          sh_rx_clr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sclk      <= 1'b0;
      sync_n    <= 1'b1;
      done      <= 1'b0;
      rd_valid  <= 1'b0;
      half_r    <= HS;
      bits_left <= '0;
      read_pend <= 1'b0;
      in_read   <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ev_accept) begin
            st        <= S_LEAD;
            sync_n    <= 1'b0;
            half_r    <= (kind == K_HOLD) ? HF : HS;
            bits_left <= frame_len(kind);
            read_pend <= (kind == K_RDBK);
            in_read   <= 1'b0;
          end
        end
        S_LEAD: begin
          if (tmr_expire) begin
            st   <= S_HIGH;
            sclk <= 1'b1;
          end
        end
        S_HIGH: begin
          if (tmr_expire) begin
            st        <= S_LOW;
            sclk      <= 1'b0;
            bits_left <= bits_left - 1'b1;
            rd_valid  <= in_read && (bits_left == LEN_W'(1));
          end
        end
        S_LOW: begin
          if (tmr_expire) begin
            if (bits_left == '0) begin
              st      <= S_GAP;
              sync_n  <= 1'b1;
              in_read <= 1'b0;
            end else begin
              st   <= S_HIGH;
              sclk <= 1'b1;
            end
          end
        end
        S_GAP: begin
          if (tmr_expire) begin
            if (read_pend) begin
              st        <= S_LEAD;
              sync_n    <= 1'b0;
              in_read   <= 1'b1;
              read_pend <= 1'b0;
              bits_left <= LEN_W'(LEN_READ);
              half_r    <= HS;
            end else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_serial_host.sv
module dac_serial_host
  import dsh_pkg::*;
#(
  parameter int CLK_PS    = 5000,
  parameter int HALF_FAST = 5,
  parameter int HALF_SLOW = 8,
  parameter int GAP_CYC   = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_kind,
  input  logic [WORD_W-1:0]   cmd_word,
  output logic                busy,
  output logic                done,
  output logic                sclk,
  output logic                sync_n,
  output logic                din,
  input  logic                dout,
  output logic                rd_valid,
  output logic [LEN_READ-1:0] rd_data
);
  localparam int MAX_HALF = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int MAX_CNT  = (GAP_CYC > MAX_HALF) ? GAP_CYC : MAX_HALF;
  localparam int TW       = $clog2(MAX_CNT + 1);

  if (!half_ok(HALF_FAST, CLK_PS, 20000, 50000)) begin : g_bad_fast
    $error("direct-hold half period too short for clock period");
  end
  if (!half_ok(HALF_SLOW, CLK_PS, 28000, 71429)) begin : g_bad_slow
    $error("DAC/readback half period too short for clock period");
  end
  if (GAP_CYC * CLK_PS < 400000) begin : g_bad_gap
    $error("inter-frame gap shorter than 400 ns");
  end

  // Internal events, brought out as named wires.
  logic             tmr_load;
  logic [TW-1:0]    tmr_val;
  logic             tmr_expire;
  logic             sh_load;
  logic             sh_take_cmd;
  logic [LEN_W-1:0] sh_len;
  logic             sh_shift;
  logic             sh_capture;
  logic             sh_rx_clr;
  logic             in_read;
  logic             ev_fall;
  logic             ev_accept;
  logic [WORD_W-1:0] load_word;

  assign load_word = sh_take_cmd ? align_msb(cmd_word, sh_len) : '0;

  dsh_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  dsh_shift #(.W(WORD_W), .RW(LEN_READ)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sh_load),
    .load_word (load_word),
    .shift     (sh_shift),
    .rx_clr    (sh_rx_clr),
    .capture   (sh_capture),
    .dout      (dout),
    .tx_msb    (din),
    .rx_word   (rd_data)
  );

  dsh_seq #(
    .TW        (TW),
    .HALF_FAST (HALF_FAST),
    .HALF_SLOW (HALF_SLOW),
    .GAP_CYC   (GAP_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .tmr_expire  (tmr_expire),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .sh_load     (sh_load),
    .sh_take_cmd (sh_take_cmd),
    .sh_len      (sh_len),
    .sh_shift    (sh_shift),
    .sh_capture  (sh_capture),
    .sh_rx_clr   (sh_rx_clr),
    .sclk        (sclk),
    .sync_n      (sync_n),
    .busy        (busy),
    .done        (done),
    .rd_valid    (rd_valid),
    .in_read     (in_read),
    .ev_fall     (ev_fall),
    .ev_accept   (ev_accept)
  );
endmodule

// File: rtl/dsh_checker.sv
module dsh_checker #(
  parameter int GAP_CYC = 80
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sync_n,
  input logic din,
  input logic busy,
  input logic done,
  input logic rd_valid,
  input logic in_read,
  input logic ev_fall
);
  logic [15:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= 16'hFFFF;
    end else if (!sync_n) begin
      gap_cnt <= '0;
    end else if (gap_cnt != 16'hFFFF) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sclk);

  p_sync_fall_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> !sclk && !$past(sclk));

  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> (gap_cnt >= 16'(GAP_CYC)));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $fell(sync_n));

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_rdv_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(ev_fall) && $past(in_read));

  p_rdv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_din_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && !$fell(sync_n) && !$rose(sclk)) |-> $stable(din));
endmodule

bind dac_serial_host dsh_checker #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .sync_n   (sync_n),
  .din      (din),
  .busy     (busy),
  .done     (done),
  .rd_valid (rd_valid),
  .in_read  (in_read),
  .ev_fall  (ev_fall)
);

// File: tb/tb_dac_serial_host.sv
`timescale 1ns/1ps
module tb_dac_serial_host;
  localparam int HF  = 5;
  localparam int HS  = 8;
  localparam int GAP = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [23:0] cmd_word = '0;
  logic        busy, done, sclk, sync_n, din, rd_valid;
  logic        dout = 1'b0;
  logic [13:0] rd_data;

  always #2.5 clk = ~clk;

  dac_serial_host #(.CLK_PS(5000), .HALF_FAST(HF), .HALF_SLOW(HS), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_word(cmd_word), .busy(busy), .done(done), .sclk(sclk), .sync_n(sync_n),
    .din(din), .dout(dout), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int          len;
    logic [23:0] bits;
    int          half;
    bit          rd;
    string       req;
  } frm_t;

  frm_t        exp_q[$];
  logic [13:0] rd_q[$];
  logic [13:0] pat_q[$];

  task automatic push_frm(input int len, input logic [23:0] bits, input int half,
                          input bit rd, input string req);
    frm_t f;
    f.len = len; f.bits = bits; f.half = half; f.rd = rd; f.req = req;
    exp_q.push_back(f);
  endtask

  // Driver: waits for idle, records expectations, presents one command.
  task automatic issue(input logic [1:0] k, input logic [23:0] w, input logic [13:0] pat);
    bit waited = 0;
    @(negedge clk);
    while (busy) begin
      waited = 1;
      @(negedge clk);
    end
    if (waited) chk(done == 1'b1, "R9", "done in first idle cycle", done, 1);
    case (k)
      2'd0: push_frm(10, w & 24'h3FF, HF, 0, "R2");
      2'd1: push_frm(24, w, HS, 0, "R3");
      default: begin
        push_frm(10, w & 24'h3FF, HS, 0, "R4");
        push_frm(14, 24'h0, HS, 1, "R4");
        pat_q.push_back(pat);
        rd_q.push_back(pat);
      end
    endcase
    cmd_kind  = k;
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(sync_n == 1'b0 && busy == 1'b1, "R8", "frame start after accept",
        {30'd0, sync_n, busy}, 32'h1);
  endtask

  task automatic poke();
    @(negedge clk);
    cmd_kind  = 2'd1;
    cmd_word  = 24'hFFFFFF;
    cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // Monitor: decodes frames from the pins and compares with the queue.
  bit          prev_sclk = 0, prev_sync = 1, prev_din = 0, in_frame = 0;
  int          run = 0, nfall = 0, rises = 0, gap_cnt = 1000;
  logic [23:0] got = '0;
  logic [13:0] pat = '0;
  bit          tim_ok = 1, din_ok = 1;
  frm_t        cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_sync && !sync_n) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected frame", 1, 0);
          cur.len = 0; cur.bits = '0; cur.half = HS; cur.rd = 0; cur.req = "R8";
        end else begin
          cur = exp_q.pop_front();
          if (cur.rd) chk(gap_cnt == GAP, "R7", "setup-to-read gap", gap_cnt, GAP);
          else        chk(gap_cnt >= GAP, "R7", "inter-frame gap", gap_cnt, GAP);
        end
        if (cur.rd && pat_q.size() != 0) pat = pat_q.pop_front();
        in_frame = 1; run = 1; nfall = 0; rises = 0; got = '0;
        tim_ok = !sclk; din_ok = 1;
      end else if (!sync_n && in_frame) begin
        if (sclk != prev_sclk) begin
          if (run != cur.half) tim_ok = 0;
          run = 1;
          if (sclk) begin
            if (cur.rd && rises < 14) dout = pat[13 - rises];
            rises++;
          end else begin
            nfall++;
            got = {got[22:0], din};
          end
        end else begin
          run++;
        end
        if (din != prev_din && !(sclk && !prev_sclk)) din_ok = 0;
      end else if (!prev_sync && sync_n && in_frame) begin
        if (run != cur.half) tim_ok = 0;
        chk(nfall == cur.len, cur.req, "falling edge count", nfall, cur.len);
        chk(got == cur.bits, cur.req, "frame bits", got, cur.bits);
        chk(tim_ok, "R6", "sclk half periods", tim_ok, 1);
        chk(din_ok, "R10", "din changes only on sclk rise", din_ok, 1);
        in_frame = 0;
        gap_cnt  = 0;
        dout     = 1'b0;
      end
      if (sync_n) gap_cnt++;
      if (rd_valid) begin
        if (rd_q.size() == 0) begin
          chk(0, "R5", "unexpected rd_valid", 1, 0);
        end else begin
          logic [13:0] e;
          e = rd_q.pop_front();
          chk(rd_data == e, "R5", "read data", rd_data, e);
          chk(in_frame && cur.rd && nfall == 14 && prev_sclk && !sclk, "R5",
              "rd_valid after 14th fall", nfall, 14);
        end
      end
      prev_sclk = sclk;
      prev_sync = sync_n;
      prev_din  = din;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(sync_n == 1 && sclk == 0 && din == 0 && busy == 0 && done == 0 && rd_valid == 0,
        "R1", "reset outputs", {26'd0, sync_n, sclk, din, busy, done, rd_valid}, 32'h20);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync_n == 1 && busy == 0, "R1", "idle after reset", {sync_n, busy}, 2'b10);

    issue(2'd0, 24'hFFF2A5, '0);          // R2: upper bits must be dropped
    issue(2'd1, 24'hA5C3F1, '0);          // R3
    poke();                               // R8: ignored while busy
    issue(2'd2, 24'h0001F3, 14'h2D6B);    // R4, R5
    @(negedge clk);
    while (!(sync_n && busy)) @(negedge clk);
    poke();                               // R8: ignored inside readback gap
    issue(2'd1, 24'h000000, '0);
    issue(2'd1, 24'hFFFFFF, '0);
    issue(2'd0, 24'h0003FF, '0);
    issue(2'd2, 24'h000200, 14'h3FFF);
    issue(2'd2, 24'h000001, 14'h2001);
    issue(2'd0, 24'h000155, '0);
    wait_idle();

    begin
      bit quiet = 1;
      cmd_kind  = 2'd3;
      cmd_word  = 24'h123456;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (6) begin
        if (!sync_n || busy) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R8", "reserved kind ignored", quiet, 1);
    end

    issue(2'd1, 24'h5A5A5A, '0);
    wait_idle();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all expected frames seen", exp_q.size(), 0);
    chk(rd_q.size() == 0, "R5", "all read words seen", rd_q.size(), 0);
    summary();
    $finish;
  end
endmodule